// File: doc/BRIEF.md
# Byte FIFO with Watermark Alerts

This block is a 64-entry byte queue placed between a host register port and an internal serial engine. Both sides can put bytes in and take bytes out. The host has a write port and a read port. The engine has a push port and a pop port. The data leaving the queue is shown at the head, so a read returns the oldest byte in the same cycle that the read strobe is high. When both sides touch the queue in one cycle, the host is served and the engine is told to retry.

The block keeps a 7-bit fill count and a programmable 6-bit threshold. It compares both against the threshold and drives two alert outputs. The high alert watches the remaining free space, and the low alert watches the stored byte count. A write into a full queue is dropped and sets a sticky overflow flag. A flush pulse empties the queue and clears that flag.

Top module: `byte_fifo_wm`

## Requirements
- R1: After reset the fill level is 0, the threshold is 8, the overflow flag is 0, the low alert is 1 and the high alert is 0.
- R2: Bytes leave in the order they were accepted, whichever port wrote or reads them. The head byte appears on both read-data outputs in the cycle the read strobe is high. An accepted write raises the level by one and a read of a non-empty queue lowers it by one.
- R3: The high alert is 1 exactly when (64 − level) ≤ threshold. With the threshold at 4, level 59 gives 0 and level 60 gives 1.
- R4: The low alert is 1 exactly when level ≤ threshold. With the threshold at 4, level 4 gives 1 and level 5 gives 0.
- R5: Pulsing the threshold load strobe stores the 6-bit threshold input on the next edge, and the stored value is shown on the threshold output.
- R6: A write from either side while the level is 64 is dropped. The stored data and the level stay unchanged, and the overflow flag becomes 1 and stays 1 until a flush.
- R7: A flush pulse sets the level to 0, resets both pointers and clears the overflow flag on the next edge. Any data access in the same cycle is ignored.
- R8: Reading an empty queue returns 0x00 and leaves the level at 0.
- R9: When a host strobe and an engine strobe are both high in one cycle, only the host operation takes effect and the engine stall output is 1 in that cycle. Otherwise the stall output is 0.
- R10: A write and a read on the same side in one cycle both take effect when the queue holds between 1 and 63 bytes, and the level stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_data | output | 8 | Head byte, 0x00 when empty |
| eng_push_en | input | 1 | Engine push strobe |
| eng_push_data | input | 8 | Engine push byte |
| eng_pop_en | input | 1 | Engine pop strobe |
| eng_pop_data | output | 8 | Head byte, 0x00 when empty |
| eng_stall | output | 1 | Engine access refused this cycle |
| flush | input | 1 | Empty the queue and clear the overflow flag |
| thresh_wr_en | input | 1 | Threshold load strobe |
| thresh_in | input | 6 | New threshold value |
| thresh | output | 6 | Current threshold |
| fill_level | output | 7 | Number of stored bytes, 0 to 64 |
| high_alert | output | 1 | Free space at or below the threshold |
| low_alert | output | 1 | Fill at or below the threshold |
| overflow_err | output | 1 | Sticky flag for a write dropped on a full queue |

## Verification
The bench walks the fill level through the alert edges at 4/5 and 59/60 with the threshold at 4. An off-by-one, or comparing fill instead of free space, would flip the high or low alert at the wrong count. It writes into a full queue from each side in turn and then reads the head back. A design that accepted the write would overwrite the oldest byte or report a level of 65. It flushes with a write pending in the same cycle and reads an empty queue: a flush that lost priority would leave one byte behind, and an empty read that moved the pointer would make the level wrap. Colliding host and engine pushes show whether the engine byte is dropped and stalled, or stored twice.

// File: rtl/fifo_wm_pkg.sv
package fifo_wm_pkg;

    localparam int unsigned BYTE_W = 8;

    // One queue operation after the host/engine arbitration
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] data;
    } fifo_op_t;

endpackage

// File: rtl/wm_arbiter.sv
module wm_arbiter
    import fifo_wm_pkg::*;
(
    input  logic              host_wr_en,
    input  logic [BYTE_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    input  logic              eng_push_en,
    input  logic [BYTE_W-1:0] eng_push_data,
    input  logic              eng_pop_en,
    output fifo_op_t          op,
    output logic              eng_stall
);
    logic host_act;
    logic eng_act;

    always_comb begin
        host_act = host_wr_en | host_rd_en;
        eng_act  = eng_push_en | eng_pop_en;
        // Host has fixed priority; the engine retries on stall
        if (host_act) begin
            op.wr   = host_wr_en;
            op.rd   = host_rd_en;
            op.data = host_wr_data;
        end else begin
            op.wr   = eng_push_en;
            op.rd   = eng_pop_en;
            op.data = eng_push_data;
        end
        eng_stall = host_act & eng_act;
    end
endmodule

// File: rtl/wm_mem.sv
module wm_mem
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/wm_alerts.sv
module wm_alerts #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned WLW   = 6,
    localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
    input  logic [LW-1:0]  level,
    input  logic [WLW-1:0] thresh,
    output logic           high_alert,
    output logic           low_alert
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [LW-1:0] free_space;
    logic [LW-1:0] thresh_ext;

    always_comb begin
        free_space = DEPTH_L - level;
        thresh_ext = {{(LW-WLW){1'b0}}, thresh};
        high_alert = (free_space <= thresh_ext);
        low_alert  = (level <= thresh_ext);
    end
endmodule

// File: rtl/byte_fifo_wm.sv
module byte_fifo_wm
    import fifo_wm_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned WLW        = 6,
    parameter int unsigned THRESH_RST = 8,
    localparam int unsigned AW        = $clog2(DEPTH),
    localparam int unsigned LW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [BYTE_W-1:0] host_wr_data,
    input  logic              host_rd_en,
    output logic [BYTE_W-1:0] host_rd_data,
    input  logic              eng_push_en,
    input  logic [BYTE_W-1:0] eng_push_data,
    input  logic              eng_pop_en,
    output logic [BYTE_W-1:0] eng_pop_data,
    output logic              eng_stall,
    input  logic              flush,
    input  logic              thresh_wr_en,
    input  logic [WLW-1:0]    thresh_in,
    output logic [WLW-1:0]    thresh,
    output logic [LW-1:0]     fill_level,
    output logic              high_alert,
    output logic              low_alert,
    output logic              overflow_err
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]  wptr;
        logic [AW-1:0]  rptr;
        logic [LW-1:0]  level;
        logic           ovf;
        logic [WLW-1:0] thr;
    } state_t;

    state_t            s_d, s_q;
    fifo_op_t          op;
    logic              mem_we;
    logic [BYTE_W-1:0] head;
    logic              is_empty;
    logic              is_full;
    logic              do_wr;
    logic              do_rd;

    wm_arbiter u_arb (
        .host_wr_en    (host_wr_en),
        .host_wr_data  (host_wr_data),
        .host_rd_en    (host_rd_en),
        .eng_push_en   (eng_push_en),
        .eng_push_data (eng_push_data),
        .eng_pop_en    (eng_pop_en),
        .op            (op),
        .eng_stall     (eng_stall)
    );

    wm_mem #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (s_q.wptr),
        .wdata (op.data),
        .raddr (s_q.rptr),
        .rdata (head)
    );

    wm_alerts #(.DEPTH(DEPTH), .WLW(WLW)) u_alerts (
        .level      (s_q.level),
        .thresh     (s_q.thr),
        .high_alert (high_alert),
        .low_alert  (low_alert)
    );

    always_comb begin
        s_d      = s_q;
        is_empty = (s_q.level == '0);
        is_full  = (s_q.level == DEPTH_L);
        do_wr    = op.wr & ~is_full & ~flush;
        do_rd    = op.rd & ~is_empty & ~flush;
        mem_we   = do_wr;

        if (flush) begin
            s_d.wptr  = '0;
            s_d.rptr  = '0;
            s_d.level = '0;
            s_d.ovf   = 1'b0;
        end else begin
            if (do_wr) begin
                s_d.wptr = s_q.wptr + 1'b1;
            end
            if (do_rd) begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
            if (op.wr && is_full) begin
                s_d.ovf = 1'b1;
            end
            s_d.level = s_q.level + {{(LW-1){1'b0}}, do_wr}
                                  - {{(LW-1){1'b0}}, do_rd};
        end

        if (thresh_wr_en) begin
            s_d.thr = thresh_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.wptr  <= '0;
            s_q.rptr  <= '0;
            s_q.level <= '0;
            s_q.ovf   <= 1'b0;
            s_q.thr   <= WLW'(THRESH_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rd_data = is_empty ? '0 : head;
    assign eng_pop_data = is_empty ? '0 : head;
    assign thresh       = s_q.thr;
    assign fill_level   = s_q.level;
    assign overflow_err = s_q.ovf;
endmodule

// File: rtl/fifo_wm_checker.sv
module fifo_wm_checker #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr_en,
    input logic          host_rd_en,
    input logic          flush,
    input logic          eng_stall,
    input logic [7:0]    host_rd_data,
    input logic [LW-1:0] fill_level,
    input logic          overflow_err
);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= DEPTH_L);

    p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && !host_rd_en && !flush && fill_level < DEPTH_L)
        |=> fill_level == $past(fill_level) + 1'b1);

    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == DEPTH_L && host_wr_en && !host_rd_en && !flush)
        |=> (fill_level == DEPTH_L && overflow_err));

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_err && !flush) |=> overflow_err);

    p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_level == '0 && !overflow_err));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (host_rd_data == 8'h00));

    p_stall_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stall |-> (host_wr_en || host_rd_en));
endmodule

bind byte_fifo_wm fifo_wm_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_rd_en   (host_rd_en),
    .flush        (flush),
    .eng_stall    (eng_stall),
    .host_rd_data (host_rd_data),
    .fill_level   (fill_level),
    .overflow_err (overflow_err)
);

// File: tb/byte_fifo_wm_test.sv
module byte_fifo_wm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0;
    logic [7:0] host_wr_data = '0;
    logic       host_rd_en = 1'b0;
    logic [7:0] host_rd_data;
    logic       eng_push_en = 1'b0;
    logic [7:0] eng_push_data = '0;
    logic       eng_pop_en = 1'b0;
    logic [7:0] eng_pop_data;
    logic       eng_stall;
    logic       flush = 1'b0;
    logic       thresh_wr_en = 1'b0;
    logic [5:0] thresh_in = '0;
    logic [5:0] thresh;
    logic [6:0] fill_level;
    logic       high_alert;
    logic       low_alert;
    logic       overflow_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    byte_fifo_wm uut (
        .clk (clk), .rst_n (rst_n),
        .host_wr_en (host_wr_en), .host_wr_data (host_wr_data),
        .host_rd_en (host_rd_en), .host_rd_data (host_rd_data),
        .eng_push_en (eng_push_en), .eng_push_data (eng_push_data),
        .eng_pop_en (eng_pop_en), .eng_pop_data (eng_pop_data),
        .eng_stall (eng_stall), .flush (flush),
        .thresh_wr_en (thresh_wr_en), .thresh_in (thresh_in), .thresh (thresh),
        .fill_level (fill_level), .high_alert (high_alert),
        .low_alert (low_alert), .overflow_err (overflow_err)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic host_write(logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b;
        cyc();
        host_wr_en = 1'b0;
    endtask

    task automatic eng_push(logic [7:0] b);
        eng_push_en = 1'b1; eng_push_data = b;
        cyc();
        eng_push_en = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] b);
        host_rd_en = 1'b1;
        #1 b = host_rd_data;
        cyc();
        host_rd_en = 1'b0;
    endtask

    task automatic eng_pop(output logic [7:0] b);
        eng_pop_en = 1'b1;
        #1 b = eng_pop_data;
        cyc();
        eng_pop_en = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        cyc();
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "level", fill_level, 0);
        chk("R1", "threshold", thresh, 8);
        chk("R1", "overflow", overflow_err, 0);
        chk("R1", "low alert", low_alert, 1);
        chk("R1", "high alert", high_alert, 0);
    endtask

    task automatic t_order();
        logic [7:0] b;
        for (int i = 0; i < 5; i++) host_write(8'hA0 + 8'(i));
        chk("R2", "level after 5 writes", fill_level, 5);
        for (int i = 0; i < 5; i++) begin
            eng_pop(b);
            chk("R2", "pop order", b, 8'hA0 + i);
        end
        chk("R2", "level after drain", fill_level, 0);
    endtask

    task automatic t_empty();
        logic [7:0] b;
        host_read(b);
        chk("R8", "empty host read", b, 0);
        eng_pop(b);
        chk("R8", "empty engine pop", b, 0);
        chk("R8", "level stays", fill_level, 0);
    endtask

    task automatic t_alerts_overflow();
        logic [7:0] b;
        thresh_wr_en = 1'b1; thresh_in = 6'd4;
        cyc();
        thresh_wr_en = 1'b0;
        chk("R5", "threshold load", thresh, 4);
        for (int i = 0; i < 4; i++) eng_push(8'h40 + 8'(i));
        chk("R4", "low at level 4", low_alert, 1);
        eng_push(8'h44);
        chk("R4", "low at level 5", low_alert, 0);
        for (int i = 5; i < 59; i++) eng_push(8'h40 + 8'(i));
        chk("R3", "high at level 59", high_alert, 0);
        eng_push(8'h40 + 8'd59);
        chk("R3", "high at level 60", high_alert, 1);
        for (int i = 60; i < 64; i++) eng_push(8'h40 + 8'(i));
        chk("R6", "full level", fill_level, 64);
        chk("R6", "no overflow yet", overflow_err, 0);
        host_write(8'hEE);
        chk("R6", "host overflow flag", overflow_err, 1);
        chk("R6", "level unchanged", fill_level, 64);
        host_read(b);
        chk("R6", "head untouched", b, 8'h40);
        chk("R6", "sticky after read", overflow_err, 1);
        do_flush();
        chk("R7", "flush level", fill_level, 0);
        chk("R7", "flush overflow", overflow_err, 0);
        for (int i = 0; i < 64; i++) eng_push(8'(i));
        eng_push(8'hDD);
        chk("R6", "engine overflow flag", overflow_err, 1);
        chk("R6", "engine level unchanged", fill_level, 64);
        flush = 1'b1; host_wr_en = 1'b1; host_wr_data = 8'h77;
        cyc();
        flush = 1'b0; host_wr_en = 1'b0;
        chk("R7", "flush beats write level", fill_level, 0);
        chk("R7", "flush clears flag", overflow_err, 0);
    endtask

    task automatic t_priority();
        logic [7:0] b;
        host_wr_en = 1'b1; host_wr_data = 8'h11;
        eng_push_en = 1'b1; eng_push_data = 8'h22;
        #1 chk("R9", "stall on collision", eng_stall, 1);
        cyc();
        host_wr_en = 1'b0; eng_push_en = 1'b0;
        chk("R9", "only host stored", fill_level, 1);
        eng_push_en = 1'b1; eng_push_data = 8'h22;
        #1 chk("R9", "no stall when alone", eng_stall, 0);
        cyc();
        eng_push_en = 1'b0;
        host_read(b);
        chk("R9", "host byte first", b, 8'h11);
        host_read(b);
        chk("R9", "engine retry byte", b, 8'h22);
        chk("R9", "empty after", fill_level, 0);
    endtask

    task automatic t_same_port();
        logic [7:0] b;
        host_write(8'h31);
        host_write(8'h32);
        host_wr_en = 1'b1; host_wr_data = 8'h33; host_rd_en = 1'b1;
        #1 b = host_rd_data;
        cyc();
        host_wr_en = 1'b0; host_rd_en = 1'b0;
        chk("R10", "read during write", b, 8'h31);
        chk("R10", "level held", fill_level, 2);
        host_read(b);
        chk("R10", "next byte", b, 8'h32);
        host_read(b);
        chk("R10", "written byte", b, 8'h33);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_order();
        t_empty();
        t_alerts_overflow();
        t_priority();
        t_same_port();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule